// File: doc/BRIEF.md
# Circuit Path Reservation Router

This block is the electronic control router placed beside a blocking 4x4 optical switch. The switch is built from four 2x2 switching elements. The router has four bidirectional control ports, named north, east, south and west. Each port carries one fixed-width control word per cycle. A setup word chooses its exit port by dimension-order routing, first along X and then along Y. If the setup can be granted, the router reserves a connection from its entry port to its exit port, commits the switching elements that the connection needs, and forwards the word unchanged. The connection stays held until a teardown word with the same flow identifier travels back along the path.

A setup is refused in four cases: it would make a U-turn, its entry port already holds a circuit, its exit is already reserved, or it needs an element that is held in the opposite state. A refused setup goes back out of its own port as a blocked word. Only one setup is admitted per cycle. The choice goes to the highest priority, and ties are broken round-robin. A setup that loses arbitration, or whose outgoing port is occupied in that cycle, is held at its port with its ready low and tries again in the next cycle. A teardown whose flow has no reservation is dropped and flagged.

Top module: `cpr_router`

## Requirements
- R1: Word layout from MSB: kind (2 bits: 00 idle, 01 setup, 10 teardown, 11 blocked), priority (2), flow (4), destination X (3), destination Y (3). Incoming idle and blocked words are consumed with no output and no change of state.
- R2: Ports are 0 north (+Y), 1 east (+X), 2 south, 3 west. The exit port is east or west until X matches the router's own X, then north or south until Y matches. At the router's own coordinates the exit is the ejection port (default 2).
- R3: A setup whose exit port equals its entry port is never granted.
- R4: Connection i to o commits elements as follows. Straight (o=i+2 mod 4) sets element i off. Right turn (o=i+1) sets element i on. Left turn (o=i+3) sets elements i and o on. pse_on bit e is high while a held circuit sets element e on. A setup needing an element that is held in the other state is refused.
- R5: A setup is refused when its exit port is already reserved or its entry port already holds a circuit.
- R6: A refused setup leaves through its own entry port one cycle after acceptance, with kind 11 and all other fields unchanged.
- R7: A granted setup leaves unchanged through its exit port one cycle after acceptance, and its reservation is held from then on.
- R8: A teardown arriving on the reserved exit port of a circuit with the same flow releases that circuit. It leaves unchanged through the circuit's entry port one cycle later, and pse_on follows the release in the same cycle.
- R9: A teardown with no matching circuit produces no output and raises err_orphan for exactly one cycle.
- R10: At most one setup is granted per cycle. The highest priority wins. Ties are broken round-robin, starting at the port after the last winner (port 0 after reset). Grantable setups that lose keep in_ready low.
- R11: All decisions in a cycle use the reservation state at the start of that cycle. Outgoing port use has this precedence: teardown forwards, then the granted setup, then blocked replies. A word whose outgoing port is taken waits with in_ready low.
- R12: After reset no circuit is held and out_valid, pse_on and err_orphan are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | A control word is offered on each port |
| in_word | input | 4x14 | Incoming control word per port |
| in_ready | output | 4 | The offered word is consumed at this edge |
| out_valid | output | 4 | An outgoing word is present per port |
| out_word | output | 4x14 | Outgoing control word per port |
| err_orphan | output | 1 | One-cycle flag for an unmatched teardown |
| pse_on | output | 4 | On/off enables of the four switching elements |

## Verification
Two things can happen in the same cycle: a teardown can free an exit port while a setup asks for that same port. The bench offers both words in one cycle. It expects the setup to be refused, because the state at the start of the cycle still holds the port. The teardown must be forwarded out of the circuit's entry port, and the blocked reply must return on the setup's own port, both in the next cycle. The same setup is then offered again and must be granted. Other cases drive simultaneous setups. In these the bench checks which ports see in_ready, which shows that priority overrides the round-robin order and that the round-robin pointer moves after each winner.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
    parameter int CW     = 3;
    parameter int FLOW_W = 4;
    parameter int PRIO_W = 2;
    localparam int WORD_W = 2 + PRIO_W + FLOW_W + 2 * CW;

    typedef enum logic [1:0] {
        PK_IDLE  = 2'b00,
        PK_SETUP = 2'b01,
        PK_TEAR  = 2'b10,
        PK_BLOCK = 2'b11
    } pkt_kind_e;

    typedef struct packed {
        pkt_kind_e         kind;
        logic [PRIO_W-1:0] prio;
        logic [FLOW_W-1:0] flow;
        logic [CW-1:0]     dx;
        logic [CW-1:0]     dy;
    } ctl_word_t;

    typedef logic [1:0] port_t;

    localparam port_t P_N = 2'd0;
    localparam port_t P_E = 2'd1;
    localparam port_t P_S = 2'd2;
    localparam port_t P_W = 2'd3;

    typedef struct packed {
        logic [3:0] need_on;
        logic [3:0] need_off;
    } elem_use_t;

    // element states demanded by a connection from port i to port o
    function automatic elem_use_t elem_need(input port_t i, input port_t o);
        elem_use_t r;
        r = '0;
        if (o == port_t'(i + 2'd2)) begin
            r.need_off[i] = 1'b1;
        end else if (o == port_t'(i + 2'd1)) begin
            r.need_on[i] = 1'b1;
        end else if (o == port_t'(i + 2'd3)) begin
            r.need_on[i] = 1'b1;
            r.need_on[o] = 1'b1;
        end
        return r;
    endfunction

    // dimension order: X first, then Y, then the ejection port
    function automatic port_t xy_route(input ctl_word_t wd, input logic [CW-1:0] mx,
                                       input logic [CW-1:0] my, input port_t ej);
        if (wd.dx > mx)      return P_E;
        else if (wd.dx < mx) return P_W;
        else if (wd.dy > my) return P_N;
        else if (wd.dy < my) return P_S;
        else                 return ej;
    endfunction
endpackage

// File: rtl/cpr_arbiter.sv
module cpr_arbiter
    import cpr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [3:0]             req,
    input  logic [3:0][PRIO_W-1:0] prio,
    output logic                   gnt_valid,
    output port_t                  gnt_idx
);
    port_t ptr;

    always_comb begin
        port_t             idx;
        logic [PRIO_W-1:0] best;
        gnt_valid = 1'b0;
        gnt_idx   = ptr;
        best      = '0;
        for (int k = 0; k < 4; k++) begin
            idx = port_t'(ptr + port_t'(k));
            if (req[idx] && (!gnt_valid || prio[idx] > best)) begin
                gnt_valid = 1'b1;
                gnt_idx   = idx;
                best      = prio[idx];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            ptr <= P_N;
        else if (gnt_valid) ptr <= port_t'(gnt_idx + 2'd1);
    end
endmodule

// File: rtl/cpr_table.sv
module cpr_table
    import cpr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   set_en,
    input  port_t                  set_in,
    input  port_t                  set_out,
    input  logic [FLOW_W-1:0]      set_flow,
    input  logic [3:0]             clr_mask,
    output logic [3:0]             slot_vld,
    output port_t [3:0]            slot_out,
    output logic [3:0][FLOW_W-1:0] slot_flow,
    output logic [3:0]             held_on,
    output logic [3:0]             held_off
);
    // one slot per entry port: a port can source only one circuit
    for (genvar s = 0; s < 4; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_vld[s]  <= 1'b0;
                slot_out[s]  <= P_N;
                slot_flow[s] <= '0;
            end else if (clr_mask[s]) begin
                slot_vld[s]  <= 1'b0;
            end else if (set_en && set_in == port_t'(s)) begin
                slot_vld[s]  <= 1'b1;
                slot_out[s]  <= set_out;
                slot_flow[s] <= set_flow;
            end
        end
    end

    always_comb begin
        elem_use_t u;
        held_on  = '0;
        held_off = '0;
        for (int s = 0; s < 4; s++) begin
            u = elem_need(port_t'(s), slot_out[s]);
            if (slot_vld[s]) begin
                held_on  = held_on  | u.need_on;
                held_off = held_off | u.need_off;
            end
        end
    end
endmodule

// File: rtl/cpr_router.sv
module cpr_router
    import cpr_pkg::*;
#(
    parameter int MY_X       = 2,
    parameter int MY_Y       = 2,
    parameter int EJECT_PORT = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [3:0]             in_valid,
    input  logic [3:0][WORD_W-1:0] in_word,
    output logic [3:0]             in_ready,
    output logic [3:0]             out_valid,
    output logic [3:0][WORD_W-1:0] out_word,
    output logic                   err_orphan,
    output logic [3:0]             pse_on
);
    localparam logic [CW-1:0] MX = CW'(MY_X);
    localparam logic [CW-1:0] MY = CW'(MY_Y);
    localparam port_t         EJ = port_t'(EJECT_PORT);

    ctl_word_t                w [4];
    port_t     [3:0]          rt;
    elem_use_t                need [4];
    logic      [3:0]          is_set, is_tear, is_other;
    logic      [3:0]          out_busy, grantable, req;
    logic      [3:0]          tear_hit, tear_fwd, blk_ok;
    port_t     [3:0]          tear_slot;
    logic      [3:0][PRIO_W-1:0] prio_v;
    logic                     gnt_valid;
    port_t                    gnt_idx, win_port;
    logic      [3:0]          slot_vld, held_on, held_off;
    port_t     [3:0]          slot_out;
    logic      [3:0][FLOW_W-1:0] slot_flow;
    logic      [3:0]          nxt_v;
    ctl_word_t                nxt_w [4];
    logic                     nxt_err;

    // parse and route every port
    always_comb begin
        for (int p = 0; p < 4; p++) begin
            w[p]        = ctl_word_t'(in_word[p]);
            is_set[p]   = in_valid[p] && w[p].kind == PK_SETUP;
            is_tear[p]  = in_valid[p] && w[p].kind == PK_TEAR;
            is_other[p] = in_valid[p] && !is_set[p] && !is_tear[p];
            rt[p]       = xy_route(w[p], MX, MY, EJ);
            need[p]     = elem_need(port_t'(p), rt[p]);
            prio_v[p]   = w[p].prio;
        end
    end

    // admission against the state held at the start of the cycle
    always_comb begin
        out_busy = '0;
        for (int s = 0; s < 4; s++)
            if (slot_vld[s]) out_busy[slot_out[s]] = 1'b1;
        for (int p = 0; p < 4; p++)
            grantable[p] = is_set[p] && rt[p] != port_t'(p) && !slot_vld[p]
                           && !out_busy[rt[p]]
                           && (need[p].need_on & held_off) == 4'b0
                           && (need[p].need_off & held_on) == 4'b0;
    end

    // teardown matching on exit port and flow
    always_comb begin
        tear_fwd = '0;
        for (int p = 0; p < 4; p++) begin
            tear_hit[p]  = 1'b0;
            tear_slot[p] = P_N;
            for (int s = 0; s < 4; s++)
                if (is_tear[p] && slot_vld[s] && slot_out[s] == port_t'(p)
                    && slot_flow[s] == w[p].flow) begin
                    tear_hit[p]  = 1'b1;
                    tear_slot[p] = port_t'(s);
                end
            if (tear_hit[p]) tear_fwd[tear_slot[p]] = 1'b1;
        end
        for (int p = 0; p < 4; p++) req[p] = grantable[p] && !tear_fwd[rt[p]];
    end

    cpr_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .prio      (prio_v),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    assign win_port = rt[gnt_idx];

    always_comb begin
        for (int p = 0; p < 4; p++) begin
            blk_ok[p] = is_set[p] && !grantable[p] && !tear_fwd[p]
                        && !(gnt_valid && win_port == port_t'(p));
            in_ready[p] = is_tear[p] || is_other[p] || blk_ok[p]
                          || (gnt_valid && gnt_idx == port_t'(p));
        end
    end

    cpr_table u_tab (
        .clk       (clk),
        .rst       (rst),
        .set_en    (gnt_valid),
        .set_in    (gnt_idx),
        .set_out   (win_port),
        .set_flow  (w[gnt_idx].flow),
        .clr_mask  (tear_fwd),
        .slot_vld  (slot_vld),
        .slot_out  (slot_out),
        .slot_flow (slot_flow),
        .held_on   (held_on),
        .held_off  (held_off)
    );

    assign pse_on = held_on;

    // outgoing words: teardown forwards, winner, blocked replies
    always_comb begin
        nxt_v   = '0;
        nxt_err = 1'b0;
        for (int p = 0; p < 4; p++) nxt_w[p] = '0;
        for (int p = 0; p < 4; p++) begin
            if (tear_hit[p]) begin
                nxt_v[tear_slot[p]] = 1'b1;
                nxt_w[tear_slot[p]] = w[p];
            end
            if (is_tear[p] && !tear_hit[p]) nxt_err = 1'b1;
        end
        if (gnt_valid) begin
            nxt_v[win_port] = 1'b1;
            nxt_w[win_port] = w[gnt_idx];
        end
        for (int p = 0; p < 4; p++)
            if (blk_ok[p]) begin
                nxt_v[p]      = 1'b1;
                nxt_w[p]      = w[p];
                nxt_w[p].kind = PK_BLOCK;
            end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= '0;
            err_orphan <= 1'b0;
            for (int p = 0; p < 4; p++) out_word[p] <= '0;
        end else begin
            out_valid  <= nxt_v;
            err_orphan <= nxt_err;
            for (int p = 0; p < 4; p++) out_word[p] <= nxt_w[p];
        end
    end
endmodule

// File: rtl/cpr_checker.sv
module cpr_checker
    import cpr_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [3:0]             in_valid,
    input logic [3:0]             in_ready,
    input logic [3:0][WORD_W-1:0] in_word,
    input logic [3:0]             out_valid,
    input logic [3:0][WORD_W-1:0] out_word,
    input logic                   err_orphan,
    input logic [3:0]             slot_vld,
    input port_t [3:0]            slot_out,
    input logic [3:0]             held_on,
    input logic [3:0]             held_off
);
    for (genvar p = 0; p < 4; p++) begin : g_port
        AST_NO_UTURN: assert property (@(posedge clk) disable iff (rst)
            slot_vld[p] |-> slot_out[p] != port_t'(p)); // R3
        AST_BLOCK_HOME: assert property (@(posedge clk) disable iff (rst)
            (out_valid[p] && out_word[p][WORD_W-1 -: 2] == 2'b11)
            |-> $past(in_valid[p] && in_ready[p])); // R6
        AST_SETUP_LATENCY: assert property (@(posedge clk) disable iff (rst)
            (in_valid[p] && in_ready[p] && in_word[p][WORD_W-1 -: 2] == 2'b01)
            |=> (out_valid != 4'b0)); // R7
        for (genvar q = p + 1; q < 4; q++) begin : g_pair
            AST_OUT_EXCL: assert property (@(posedge clk) disable iff (rst)
                !(slot_vld[p] && slot_vld[q] && slot_out[p] == slot_out[q])); // R5
        end
    end

    AST_ELEM_STATE: assert property (@(posedge clk) disable iff (rst)
        (held_on & held_off) == 4'b0); // R4
    AST_ORPHAN_SRC: assert property (@(posedge clk) disable iff (rst)
        err_orphan |-> $past(in_valid != 4'b0)); // R9
endmodule

bind cpr_router cpr_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_word    (in_word),
    .out_valid  (out_valid),
    .out_word   (out_word),
    .err_orphan (err_orphan),
    .slot_vld   (slot_vld),
    .slot_out   (slot_out),
    .held_on    (held_on),
    .held_off   (held_off)
);

// File: tb/cpr_router_tb_top.sv
`timescale 1ns/100ps
module cpr_router_tb_top;
    import cpr_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [3:0]             in_valid = '0;
    logic [3:0][WORD_W-1:0] in_word = '0;
    logic [3:0]             in_ready;
    logic [3:0]             out_valid;
    logic [3:0][WORD_W-1:0] out_word;
    logic                   err_orphan;
    logic [3:0]             pse_on;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    ctl_word_t exp_q [4][$];
    string     tag_q [4][$];
    logic [3:0] st_v = '0;
    ctl_word_t  st_w [4];

    always #2.5 clk = ~clk;

    cpr_router dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_word   (out_word),
        .err_orphan (err_orphan),
        .pse_on     (pse_on)
    );

    function automatic ctl_word_t mk(pkt_kind_e k, int pr, int fl, int x, int y);
        ctl_word_t r;
        r.kind = k;
        r.prio = PRIO_W'(pr);
        r.flow = FLOW_W'(fl);
        r.dx   = CW'(x);
        r.dy   = CW'(y);
        return r;
    endfunction

    function automatic ctl_word_t as_block(ctl_word_t wd);
        ctl_word_t r = wd;
        r.kind = PK_BLOCK;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic offer(input int p, input ctl_word_t wd);
        st_v[p]  = 1'b1;
        st_w[p]  = wd;
    endtask

    task automatic expect_out(input int p, input ctl_word_t wd, input string tag);
        exp_q[p].push_back(wd);
        tag_q[p].push_back(tag);
    endtask

    task automatic step(input logic [3:0] exp_rdy, input string tag);
        @(negedge clk);
        in_valid = st_v;
        for (int p = 0; p < 4; p++) in_word[p] = st_w[p];
        #1;
        chk((in_ready & st_v) == exp_rdy, tag, 32'(in_ready & st_v), 32'(exp_rdy));
        @(posedge clk);
        #2;
        in_valid = '0;
        st_v     = '0;
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            for (int p = 0; p < 4; p++) begin
                if (out_valid[p]) begin
                    checks++;
                    if (exp_q[p].size() == 0) begin
                        errors++;
                        $display("FAIL R11 unexpected word on port %0d: actual %h expected none", p, out_word[p]);
                    end else begin
                        ctl_word_t ew;
                        string     et;
                        ew = exp_q[p].pop_front();
                        et = tag_q[p].pop_front();
                        if (out_word[p] !== ew) begin
                            errors++;
                            $display("FAIL %s port %0d: actual %h expected %h", et, p, out_word[p], ew);
                        end
                    end
                end
            end
        end
    end

    initial begin
        ctl_word_t wa, wb, wc, wd, we, wf, wj, wk, wm, wn, wp, wq;
        for (int p = 0; p < 4; p++) st_w[p] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        chk(out_valid == 4'b0, "R12 out_valid after reset", 32'(out_valid), 0);
        chk(pse_on == 4'b0, "R12 pse_on after reset", 32'(pse_on), 0);
        chk(err_orphan == 1'b0, "R12 err_orphan after reset", 32'(err_orphan), 0);
        @(negedge clk);
        rst = 1'b0;

        // R10 tie, pointer at port 0: north wins, west waits; R2 routes S and E
        wa = mk(PK_SETUP, 0, 2, 2, 0);
        wb = mk(PK_SETUP, 0, 1, 4, 2);
        offer(0, wa); offer(3, wb);
        expect_out(2, wa, "R2 R7 north setup routed south");
        step(4'b0001, "R10 round-robin tie from pointer 0");
        offer(3, wb);
        expect_out(1, wb, "R2 R7 west setup routed east");
        step(4'b1000, "R10 held setup admitted next");
        chk(pse_on == 4'b0000, "R4 two straight circuits", 32'(pse_on), 0);

        // R4 left turn east->north needs element 0 on, held off
        wc = mk(PK_SETUP, 0, 3, 2, 5);
        offer(1, wc);
        expect_out(1, as_block(wc), "R4 R6 element conflict blocked");
        step(4'b0010, "R6 refused setup consumed");

        // right turn south->west
        wd = mk(PK_SETUP, 1, 4, 1, 2);
        offer(2, wd);
        expect_out(3, wd, "R2 R7 south setup routed west");
        step(4'b0100, "R7 right turn granted");
        chk(pse_on == 4'b0100, "R4 element 2 on", 32'(pse_on), 32'h4);

        // R3 U-turn
        we = mk(PK_SETUP, 0, 5, 5, 3);
        offer(1, we);
        expect_out(1, as_block(we), "R3 U-turn blocked");
        step(4'b0010, "R3 U-turn consumed");

        // R11 teardown and setup of same exit in one cycle
        wf = mk(PK_SETUP, 0, 6, 2, 0);
        offer(2, mk(PK_TEAR, 0, 2, 0, 0));
        offer(1, wf);
        expect_out(0, mk(PK_TEAR, 0, 2, 0, 0), "R8 teardown forwarded to entry port");
        expect_out(1, as_block(wf), "R11 R5 setup sees busy exit from start of cycle");
        step(4'b0110, "R11 both consumed");
        offer(1, wf);
        expect_out(2, wf, "R11 retry granted after release");
        step(4'b0010, "R11 retry admitted");
        chk(pse_on == 4'b0110, "R4 R8 elements 1 and 2 on", 32'(pse_on), 32'h6);

        // R9 orphan teardown
        offer(0, mk(PK_TEAR, 0, 9, 0, 0));
        step(4'b0001, "R9 orphan consumed");
        chk(err_orphan == 1'b1, "R9 err_orphan raised", 32'(err_orphan), 1);

        // R8 teardown of west->east circuit
        offer(1, mk(PK_TEAR, 0, 1, 0, 0));
        expect_out(3, mk(PK_TEAR, 0, 1, 0, 0), "R8 teardown forwarded west");
        step(4'b0010, "R8 teardown consumed");
        chk(err_orphan == 1'b0, "R9 err_orphan one cycle", 32'(err_orphan), 0);
        chk(pse_on == 4'b0110, "R8 release of off element", 32'(pse_on), 32'h6);

        // R10 priority beats round-robin order (pointer at 2 favours west)
        wj = mk(PK_SETUP, 3, 7, 4, 2);
        wk = mk(PK_SETUP, 1, 8, 4, 2);
        offer(0, wj); offer(3, wk);
        expect_out(1, wj, "R10 higher priority forwarded");
        step(4'b0001, "R10 priority winner");
        chk(pse_on == 4'b0111, "R4 element 0 on", 32'(pse_on), 32'h7);
        offer(3, wk);
        expect_out(3, as_block(wk), "R5 exit busy blocked");
        step(4'b1000, "R5 loser refused on retry");

        // two teardowns in one cycle
        offer(1, mk(PK_TEAR, 0, 7, 0, 0));
        offer(3, mk(PK_TEAR, 0, 4, 0, 0));
        expect_out(0, mk(PK_TEAR, 0, 7, 0, 0), "R8 first teardown");
        expect_out(2, mk(PK_TEAR, 0, 4, 0, 0), "R8 second teardown");
        step(4'b1010, "R8 dual teardown consumed");
        chk(pse_on == 4'b0010, "R8 elements released", 32'(pse_on), 32'h2);

        // R10 tie with pointer at 1: west precedes north; R2 X before Y
        wm = mk(PK_SETUP, 0, 10, 4, 2);
        wn = mk(PK_SETUP, 0, 11, 4, 5);
        offer(0, wm); offer(3, wn);
        expect_out(1, wn, "R2 X corrected before Y");
        step(4'b1000, "R10 round-robin moved past last winner");
        offer(0, wm);
        expect_out(0, as_block(wm), "R5 R6 exit taken");
        step(4'b0001, "R6 retry refused");

        // ejection
        offer(2, mk(PK_TEAR, 0, 6, 0, 0));
        expect_out(1, mk(PK_TEAR, 0, 6, 0, 0), "R8 teardown to east");
        step(4'b0100, "R8 teardown consumed");
        chk(pse_on == 4'b0000, "R8 all elements off", 32'(pse_on), 0);
        wp = mk(PK_SETUP, 0, 12, 2, 2);
        offer(0, wp);
        expect_out(2, wp, "R2 own coordinates eject south");
        step(4'b0001, "R2 eject admitted");
        wq = mk(PK_SETUP, 0, 13, 2, 2);
        offer(2, wq);
        expect_out(2, as_block(wq), "R3 eject U-turn blocked");
        step(4'b0100, "R3 eject U-turn consumed");

        // R1 incoming blocked and idle words ignored
        offer(1, mk(PK_BLOCK, 0, 3, 7, 7));
        offer(3, mk(PK_IDLE, 0, 0, 0, 0));
        step(4'b1010, "R1 other kinds consumed");
        chk(pse_on == 4'b0000, "R1 no state change", 32'(pse_on), 0);

        repeat (4) @(posedge clk);
        #2;
        for (int p = 0; p < 4; p++)
            chk(exp_q[p].size() == 0, "R7 all expected words seen", 32'(exp_q[p].size()), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R11: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule